// File: doc/BRIEF.md
# Single-Wire Bus Bit-Slot Master

This block drives one open-drain data line that is shared with a responder and held high by an external pull-up resistor. The block never drives the line high. It either pulls the line low through an output enable (`line_oe`) or releases it. It reads the actual line level back on `line_in`. Each command runs one bit time slot: write-0, write-1 or read. The block handles all slot timing, the release point, the sample point and the recovery gap that must pass before the next slot may begin.

The host raises `start` for one cycle while the block is idle. In the same cycle it gives `slot_rd` (1 = read slot, 0 = write slot) and `wr_bit` (the value to write when `slot_rd` is 0). `busy` stays high for the whole slot plus the recovery time. `done` pulses for one cycle when the slot finishes, and `busy` falls at that moment. After a read slot, `rd_bit` holds the value that was sampled.

All timings are parameters counted in clock cycles. By default they are derived from `CLK_MHZ`, using these values:
- 2 µs for the short initial low.
- 65 µs for the write-0 low time.
- 13 µs for the read sample point.
- 70 µs for the slot length.
- 5 µs for the recovery time.

The line input passes through a synchroniser of `SYNC_STAGES` flops before it is used.

Top module: `sw_slot_master`

## Requirements
- R1: During reset and whenever the block is idle, `line_oe` is 0, `busy` is 0 and `done` is 0. After reset, `rd_bit` is 0.
- R2: A `start` accepted while idle sets `busy` and `line_oe` in the cycle right after the accepting clock edge.
- R3: A write-0 slot (`slot_rd`=0, `wr_bit`=0) holds `line_oe` high for exactly LOW0_CYC cycles (default 65 µs) and then releases the line.
- R4: A write-1 slot (`slot_rd`=0, `wr_bit`=1) and a read slot (`slot_rd`=1) each hold `line_oe` high for exactly LOWS_CYC cycles (default 2 µs) and then release the line.
- R5: In a read slot, `rd_bit` takes the synchronised line level present SAMP_CYC cycles (default 13 µs) after the slot start. A high level gives 1 and a low level gives 0.
- R6: `busy` stays high for exactly SLOT_CYC + RECOV_CYC cycles (default 70 µs + 5 µs). `line_oe` is 0 throughout the recovery cycles. `done` is high for exactly one cycle, in the first cycle after `busy` falls.
- R7: A `start` raised while `busy` is high is ignored. The running slot keeps its type, low time and length, and no further slot follows it.
- R8: `rd_bit` changes only at the sample point of a read slot. Write slots and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one slot (taken only when idle) |
| slot_rd | input | 1 | 1 = read slot, 0 = write slot |
| wr_bit | input | 1 | Bit to write in a write slot |
| line_in | input | 1 | Sampled level of the shared line |
| line_oe | output | 1 | 1 = pull the line low, 0 = release it |
| busy | output | 1 | Slot or recovery in progress |
| done | output | 1 | One-cycle strobe at the end of a slot |
| rd_bit | output | 1 | Bit captured by the most recent read slot |

## Verification
The bench counts every result from the clock edge that takes `start`. `busy` and `line_oe` rise one cycle after that edge. `line_oe` then stays high for LOWS_CYC or LOW0_CYC cycles, and `busy` stays high for SLOT_CYC + RECOV_CYC cycles. `done` appears in the cycle right after `busy` falls. At that point `rd_bit` already holds the value sampled SAMP_CYC cycles into the slot. The monitor samples on the falling edge and measures these run lengths from the first cycle `busy` is seen high. At each `done` it compares the measured lengths and `rd_bit` against the item the driver queued, so each result is checked at the cycle it is due.

// File: rtl/sw_slot_pkg.sv
package sw_slot_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SLOT  = 2'd1,
    PH_RECOV = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    K_WR0 = 2'd0,
    K_WR1 = 2'd1,
    K_RD  = 2'd2
  } kind_t;

  // Microseconds to clock cycles for a given clock in MHz.
  function automatic int unsigned us_to_cycles(input int unsigned us, input int unsigned mhz);
    return us * mhz;
  endfunction

  // Command pins to slot kind.
  function automatic kind_t decode_kind(input logic rd, input logic wb);
    if (rd) return K_RD;
    return wb ? K_WR1 : K_WR0;
  endfunction

  // Low time of a slot kind.
  function automatic int unsigned low_cycles(input kind_t k, input int unsigned low0,
                                             input int unsigned lows);
    return (k == K_WR0) ? low0 : lows;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_flops
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;   // released line reads high
        else        sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sw_slot_timer.sv
module sw_slot_timer
  import sw_slot_pkg::*;
#(
  parameter int unsigned SLOT_CYC  = 7000,
  parameter int unsigned RECOV_CYC = 500,
  parameter int unsigned CW        = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output phase_t        phase,
  output logic [CW-1:0] cnt,
  output logic          slot_end,
  output logic          rec_end
);
  localparam logic [CW-1:0] SLOT_LAST  = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_CYC - 1);

  assign slot_end = (phase == PH_SLOT)  && (cnt == SLOT_LAST);
  assign rec_end  = (phase == PH_RECOV) && (cnt == RECOV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (go) begin
          phase <= PH_SLOT;
          cnt   <= '0;
        end
        PH_SLOT: if (slot_end) begin
          phase <= PH_RECOV;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_RECOV: if (rec_end) begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assert_slot_to_recov_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (phase == PH_RECOV));
  assert_recov_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_end |=> (phase == PH_IDLE));
  assert_go_enters_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && go) |=> (phase == PH_SLOT && cnt == '0));
endmodule

// File: rtl/sw_slot_master.sv
module sw_slot_master
  import sw_slot_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned LOWS_CYC    = us_to_cycles(2,  CLK_MHZ),
  parameter int unsigned LOW0_CYC    = us_to_cycles(65, CLK_MHZ),
  parameter int unsigned SAMP_CYC    = us_to_cycles(13, CLK_MHZ),
  parameter int unsigned SLOT_CYC    = us_to_cycles(70, CLK_MHZ),
  parameter int unsigned RECOV_CYC   = us_to_cycles(5,  CLK_MHZ),
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic slot_rd,
  input  logic wr_bit,
  input  logic line_in,
  output logic line_oe,
  output logic busy,
  output logic done,
  output logic rd_bit
);
  localparam int unsigned CW = $clog2(max2(SLOT_CYC, RECOV_CYC) + 1);
  localparam logic [CW-1:0] LOW0_LAST = CW'(LOW0_CYC - 1);
  localparam logic [CW-1:0] LOWS_LAST = CW'(LOWS_CYC - 1);
  localparam logic [CW-1:0] SAMP_AT   = CW'(SAMP_CYC);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          slot_end, rec_end;
  logic          line_s;
  kind_t         kind_q;

  // Named internal events
  logic accept_evt, release_evt, sample_evt;

  sw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s));

  sw_slot_timer #(.SLOT_CYC(SLOT_CYC), .RECOV_CYC(RECOV_CYC), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(accept_evt), .phase(phase), .cnt(cnt),
    .slot_end(slot_end), .rec_end(rec_end));

  assign busy        = (phase != PH_IDLE);
  assign accept_evt  = start && !busy;
  assign release_evt = (phase == PH_SLOT) && line_oe &&
                       (cnt == ((kind_q == K_WR0) ? LOW0_LAST : LOWS_LAST));
  assign sample_evt  = (phase == PH_SLOT) && (kind_q == K_RD) && (cnt == SAMP_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_WR1;
      line_oe <= 1'b0;
      done    <= 1'b0;
      rd_bit  <= 1'b0;
    end else begin
      done <= rec_end;
      if (accept_evt) begin
        kind_q  <= decode_kind(slot_rd, wr_bit);
        line_oe <= 1'b1;
      end else if (release_evt) begin
        line_oe <= 1'b0;
      end
      if (sample_evt) rd_bit <= line_s;
    end
  end

  // Assertions
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_oe);
  assert_accept_pulls_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (busy && line_oe));
  assert_recov_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECOV) |-> !line_oe);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !rec_end) |=> busy);
  assert_rdbit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_evt |=> $stable(rd_bit));
  assert_released_by_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> !line_oe);
endmodule

// File: tb/tb_sw_slot_master.sv
module tb_sw_slot_master;
  localparam int MHZ   = 10;
  localparam int E_LS  = 2 * MHZ;
  localparam int E_L0  = 65 * MHZ;
  localparam int E_BSY = (70 + 5) * MHZ;
  localparam int RESP_HOLD = 15 * MHZ;

  logic clk = 0, rst_n = 0, start = 0, slot_rd = 0, wr_bit = 0;
  logic line_oe, busy, done, rd_bit, line_in;
  logic resp_low = 0, resp_zero = 0;
  int   n_chk = 0, n_fail = 0;

  typedef struct { int low; int bsy; logic rd; } exp_t;
  exp_t q[$];
  logic exp_rd = 0;

  always #5 clk = ~clk;

  assign line_in = !(line_oe || resp_low);

  sw_slot_master #(.CLK_MHZ(MHZ)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_rd(slot_rd), .wr_bit(wr_bit),
    .line_in(line_in), .line_oe(line_oe), .busy(busy), .done(done), .rd_bit(rd_bit));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Responder: drives a 0 by holding the line low for 15 us from the slot start
  int  r_cnt = 0;
  logic oe_prev = 0;
  always @(negedge clk) begin
    if (line_oe && !oe_prev && resp_zero) r_cnt = RESP_HOLD;
    else if (r_cnt > 0) r_cnt--;
    resp_low = (r_cnt > 0);
    oe_prev = line_oe;
  end

  // Monitor
  int b_cnt = 0, o_cnt = 0;
  logic b_prev = 0, d_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (!b_prev) begin
          b_cnt = 0; o_cnt = 0;
          chk(line_oe == 1'b1, "R2 oe with busy", line_oe, 1);
        end
        b_cnt++;
        if (line_oe) o_cnt++;
      end
      if (d_prev) chk(done == 1'b0, "R6 done width", done, 0);
      if (done) begin
        exp_t e;
        if (q.size() == 0) chk(1'b0, "R7 unexpected slot", 1, 0);
        else begin
          e = q.pop_front();
          chk(o_cnt == e.low, (e.low == E_L0) ? "R3 low time" : "R4 low time", o_cnt, e.low);
          chk(b_cnt == e.bsy, "R6 busy length", b_cnt, e.bsy);
          chk(rd_bit == e.rd, "R5/R8 rd_bit", rd_bit, e.rd);
          chk(!busy && !line_oe, "R1 idle after done", {busy, line_oe}, 0);
        end
      end
      b_prev = busy;
      d_prev = done;
    end
  end

  task automatic run_slot(input logic rd, input logic wb, input logic r0, input bit poke);
    exp_t e;
    resp_zero = r0;
    if (rd) exp_rd = !r0;
    e.low = (!rd && !wb) ? E_L0 : E_LS;
    e.bsy = E_BSY;
    e.rd  = exp_rd;
    q.push_back(e);
    @(negedge clk); start = 1; slot_rd = rd; wr_bit = wb;
    @(negedge clk); start = 0;
    if (poke) begin   // R7: start while busy
      repeat (100) @(negedge clk);
      start = 1; slot_rd = !rd; wr_bit = !wb;
      @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    if (poke) chk(!busy && q.size() == 0, "R7 no extra slot", busy, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(line_oe == 0 && busy == 0 && done == 0 && rd_bit == 0, "R1 reset state",
            {line_oe, busy, done, rd_bit}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(!line_oe && !busy, "R1 idle", {line_oe, busy}, 0);
        run_slot(0, 0, 0, 0);   // R3 write-0
        run_slot(0, 1, 0, 0);   // R4 write-1
        run_slot(1, 0, 0, 0);   // R5 read 1
        run_slot(1, 0, 1, 0);   // R5 read 0
        run_slot(0, 1, 0, 0);   // R8 rd_bit held at 0
        run_slot(0, 0, 0, 1);   // R7 write-0 with poke
        run_slot(1, 0, 0, 0);   // R5 read 1
        run_slot(0, 0, 0, 0);   // R8 held at 1
        run_slot(1, 0, 1, 1);   // R7 read 0 with poke
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule